// File: doc/BRIEF.md
# One-Wire Bus Timing Master

This block is the master side of a single open-drain one-wire bus. Every kind of bus slot comes from one primitive. A slot holds the line low for a programmed number of time units and captures the line level at a programmed instant. It then runs to the end of the slot and reports completion. Bus reset with presence detect, read slots and write slots are all this primitive with different pulse and sample values. A prescaler makes one time unit equal to one microsecond of the system clock, so the host programs slots directly in microseconds.

The host drives the primitive through a plain command word with a write strobe and polls a two-bit status word. A byte sequencer sits beside that path and moves whole bytes, least significant bit first. It takes write and read requests on a valid/ready input stream and returns received bytes on a valid/ready output stream.

Back-pressure on the streams works as follows. The request stream is ready only when the sequencer is idle, no slot is running and no received byte is still waiting to be taken. A received byte stays valid and unchanged until the consumer asserts ready. The pad is modelled as a drive-low enable plus a sampled input, and the block never drives the line high.

Top module: `ow_master`

## Requirements
- R1: The command word carries the sample instant in bits [11:2] and the pulse length in bits [21:12], both in time units. One unit is CLK_HZ/UNIT_HZ clock cycles.
- R2: After a command is accepted, `ow_drive_low` is high for exactly pulse×DIV cycles, starting at the accepting edge. With a pulse of 0 the line is never pulled low.
- R3: Status bit 0 returns the line level captured at unit max(sample,1) of the slot, taken through a two-flop input synchronizer.
- R4: Status bit 1 (done) clears at the accepting edge and sets exactly L×DIV cycles later, where L = max(pulse, max(sample,1)).
- R5: A command strobe is ignored while a slot is running or the byte sequencer is busy. Neither the running slot's timing nor its captured bit changes.
- R6: A write request (`bq_write`=1) sends eight slots, least significant bit first. A 1 bit is a 6-unit pulse sampled at 110. A 0 bit is an 80-unit pulse sampled at 30.
- R7: A read request (`bq_write`=0) runs eight bits. Each bit is a read slot (6-unit pulse, sample 13) followed by a recovery slot (no pulse, sample 100). Each captured bit enters at bit 7 while the byte shifts right, and the byte is returned on `br_data`.
- R8: `bq_ready` is high only when the sequencer is idle, no slot runs and no result is pending. `br_valid` and `br_data` hold steady until `br_ready`.
- R9: After reset, status is 0, the line is released, `bq_ready` is 1 and `br_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| cmd_we | input | 1 | Command write strobe |
| cmd_word | input | CMD_W | Command word (pulse and sample fields) |
| status | output | 2 | Bit 1 done, bit 0 captured line level |
| bq_valid | input | 1 | Byte request valid |
| bq_ready | output | 1 | Byte request ready |
| bq_write | input | 1 | 1 = write byte, 0 = read byte |
| bq_data | input | 8 | Byte to send |
| br_valid | output | 1 | Received byte valid |
| br_ready | input | 1 | Received byte taken |
| br_data | output | 8 | Received byte |
| ow_in | input | 1 | Line level from the pad |
| ow_drive_low | output | 1 | Pull-down enable for the pad |

## Verification
For a command accepted at edge E0, the pull-down is due in the cycle right after E0 and ends exactly pulse×DIV edges after E0. Done is due L×DIV edges after E0, and the captured bit is read at that same point. The bench therefore counts edges from the accepting edge and compares the pull-down and done at the falling edge after every one of them.

Byte transfers have no fixed latency to check against. The bench decodes written bits from the width of each low pulse and waits on the handshakes for received bytes. A simulated device answers read slots by holding the line low for 30 units when its bit is 0.

// File: rtl/ow_pkg.sv
package ow_pkg;
  localparam int unsigned OW_UNIT_W = 10;

  typedef struct packed {
    logic [OW_UNIT_W-1:0] pulse;
    logic [OW_UNIT_W-1:0] sample;
  } ow_slot_t;
endpackage

// File: rtl/ow_tick_gen.sv
module ow_tick_gen #(
  parameter int unsigned DIV = 125
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic en,
  output logic tick
);
  localparam int unsigned CW = (DIV > 2) ? $clog2(DIV) : 1;

  logic [CW-1:0] cnt;

  assign tick = en && (cnt == CW'(DIV - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (restart) begin
      cnt <= '0;
    end else if (en) begin
      if (cnt == CW'(DIV - 1)) cnt <= '0;
      else                     cnt <= cnt + 1'b1;
    end
  end

  a_r1_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
endmodule

// File: rtl/ow_slot_engine.sv
module ow_slot_engine
  import ow_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     start,
  input  ow_slot_t slot,
  input  logic     tick,
  input  logic     line_in,
  output logic     busy,
  output logic     drive_low,
  output logic     done,
  output logic     bit_q,
  output logic     fin
);
  logic [1:0]           sync;
  logic [OW_UNIT_W-1:0] ucnt, nxt;
  logic [OW_UNIT_W-1:0] pulse_q, samp_q, len_q;
  logic [OW_UNIT_W-1:0] samp_eff, len_eff;

  always_comb begin
    samp_eff = (slot.sample == '0) ? OW_UNIT_W'(1) : slot.sample;
    len_eff  = (slot.pulse > samp_eff) ? slot.pulse : samp_eff;
    nxt      = ucnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync      <= 2'b11;
      ucnt      <= '0;
      pulse_q   <= '0;
      samp_q    <= '0;
      len_q     <= '0;
      busy      <= 1'b0;
      drive_low <= 1'b0;
      done      <= 1'b0;
      bit_q     <= 1'b0;
      fin       <= 1'b0;
    end else begin
      sync <= {sync[0], line_in};
      fin  <= 1'b0;
      if (start && !busy) begin
        busy      <= 1'b1;
        done      <= 1'b0;
        ucnt      <= '0;
        pulse_q   <= slot.pulse;
        samp_q    <= samp_eff;
        len_q     <= len_eff;
        drive_low <= (slot.pulse != '0);
      end else if (busy && tick) begin
        ucnt <= nxt;
        if (nxt == pulse_q) drive_low <= 1'b0;
        if (nxt == samp_q)  bit_q     <= sync[1];
        if (nxt == len_q) begin
          busy <= 1'b0;
          done <= 1'b1;
          fin  <= 1'b1;
        end
      end
    end
  end

  a_r2_drive_in_slot: assert property (@(posedge clk) disable iff (!rst_n)
    drive_low |-> busy);
  a_r4_end_flags: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (fin && done));
  a_r4_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !done);
endmodule

// File: rtl/ow_byte_seq.sv
module ow_byte_seq
  import ow_pkg::*;
#(
  parameter int unsigned T_W1_PULSE  = 6,
  parameter int unsigned T_W1_SAMPLE = 110,
  parameter int unsigned T_W0_PULSE  = 80,
  parameter int unsigned T_W0_SAMPLE = 30,
  parameter int unsigned T_RD_PULSE  = 6,
  parameter int unsigned T_RD_SAMPLE = 13,
  parameter int unsigned T_RC_SAMPLE = 100,
  parameter int unsigned BYTE_W      = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bq_valid,
  output logic              bq_ready,
  input  logic              bq_write,
  input  logic [BYTE_W-1:0] bq_data,
  output logic              br_valid,
  input  logic              br_ready,
  output logic [BYTE_W-1:0] br_data,
  input  logic              eng_busy,
  input  logic              eng_fin,
  input  logic              eng_bit,
  output logic              req,
  output ow_slot_t          slot,
  output logic              idle
);
  localparam int unsigned BCW = $clog2(BYTE_W);

  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT, S_RESULT} seq_state_e;

  seq_state_e        state;
  logic              is_write;
  logic              phase;
  logic [BCW-1:0]    bitcnt;
  logic [BYTE_W-1:0] shreg;
  logic              last_bit;

  assign idle     = (state == S_IDLE);
  assign req      = (state == S_ISSUE);
  assign bq_ready = idle && !eng_busy;
  assign br_valid = (state == S_RESULT);
  assign br_data  = shreg;
  assign last_bit = (bitcnt == BCW'(BYTE_W - 1));

  always_comb begin
    if (is_write) begin
      slot.pulse  = shreg[0] ? OW_UNIT_W'(T_W1_PULSE)  : OW_UNIT_W'(T_W0_PULSE);
      slot.sample = shreg[0] ? OW_UNIT_W'(T_W1_SAMPLE) : OW_UNIT_W'(T_W0_SAMPLE);
    end else if (phase) begin
      slot.pulse  = '0;
      slot.sample = OW_UNIT_W'(T_RC_SAMPLE);
    end else begin
      slot.pulse  = OW_UNIT_W'(T_RD_PULSE);
      slot.sample = OW_UNIT_W'(T_RD_SAMPLE);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      is_write <= 1'b0;
      phase    <= 1'b0;
      bitcnt   <= '0;
      shreg    <= '0;
    end else begin
      case (state)
        S_IDLE: if (bq_valid && bq_ready) begin
          is_write <= bq_write;
          shreg    <= bq_write ? bq_data : '0;
          phase    <= 1'b0;
          bitcnt   <= '0;
          state    <= S_ISSUE;
        end
        S_ISSUE: if (!eng_busy) state <= S_WAIT;
        S_WAIT: if (eng_fin) begin
          if (is_write) begin
            shreg <= shreg >> 1;
            if (last_bit) state <= S_IDLE;
            else begin
              bitcnt <= bitcnt + 1'b1;
              state  <= S_ISSUE;
            end
          end else if (!phase) begin
            shreg <= {eng_bit, shreg[BYTE_W-1:1]};
            phase <= 1'b1;
            state <= S_ISSUE;
          end else begin
            phase <= 1'b0;
            if (last_bit) state <= S_RESULT;
            else begin
              bitcnt <= bitcnt + 1'b1;
              state  <= S_ISSUE;
            end
          end
        end
        S_RESULT: if (br_ready) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  a_r8_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (br_valid && !br_ready) |=> (br_valid && $stable(br_data)));
  a_r8_ready_no_result: assert property (@(posedge clk) disable iff (!rst_n)
    bq_ready |-> !br_valid);
endmodule

// File: rtl/ow_master.sv
module ow_master
  import ow_pkg::*;
#(
  parameter int unsigned CLK_HZ      = 125_000_000,
  parameter int unsigned UNIT_HZ     = 1_000_000,
  parameter int unsigned CMD_W       = 32,
  parameter int unsigned SAMPLE_LSB  = 2,
  parameter int unsigned T_W1_PULSE  = 6,
  parameter int unsigned T_W1_SAMPLE = 110,
  parameter int unsigned T_W0_PULSE  = 80,
  parameter int unsigned T_W0_SAMPLE = 30,
  parameter int unsigned T_RD_PULSE  = 6,
  parameter int unsigned T_RD_SAMPLE = 13,
  parameter int unsigned T_RC_SAMPLE = 100
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_we,
  input  logic [CMD_W-1:0] cmd_word,
  output logic [1:0]       status,
  input  logic             bq_valid,
  output logic             bq_ready,
  input  logic             bq_write,
  input  logic [7:0]       bq_data,
  output logic             br_valid,
  input  logic             br_ready,
  output logic [7:0]       br_data,
  input  logic             ow_in,
  output logic             ow_drive_low
);
  localparam int unsigned DIV       = CLK_HZ / UNIT_HZ;
  localparam int unsigned PULSE_LSB = SAMPLE_LSB + OW_UNIT_W;
  localparam int unsigned FIELD_TOP = PULSE_LSB + OW_UNIT_W;

  ow_slot_t host_slot, seq_slot, eng_slot;
  logic     eng_busy, eng_done, eng_bit, eng_fin, eng_start, tick;
  logic     seq_req, seq_idle, host_start;
  logic     unused_cmd_bits;

  assign host_slot.pulse  = cmd_word[PULSE_LSB +: OW_UNIT_W];
  assign host_slot.sample = cmd_word[SAMPLE_LSB +: OW_UNIT_W];
  assign unused_cmd_bits  = ^{cmd_word[CMD_W-1:FIELD_TOP], cmd_word[SAMPLE_LSB-1:0]};

  assign host_start = cmd_we && !eng_busy && seq_idle;
  assign eng_start  = seq_req ? !eng_busy : host_start;
  assign eng_slot   = seq_req ? seq_slot : host_slot;
  assign status     = {eng_done, eng_bit};

  ow_tick_gen #(.DIV(DIV)) u_tick (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (eng_start),
    .en      (eng_busy),
    .tick    (tick)
  );

  ow_slot_engine u_slot (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (eng_start),
    .slot      (eng_slot),
    .tick      (tick),
    .line_in   (ow_in),
    .busy      (eng_busy),
    .drive_low (ow_drive_low),
    .done      (eng_done),
    .bit_q     (eng_bit),
    .fin       (eng_fin)
  );

  ow_byte_seq #(
    .T_W1_PULSE (T_W1_PULSE),  .T_W1_SAMPLE(T_W1_SAMPLE),
    .T_W0_PULSE (T_W0_PULSE),  .T_W0_SAMPLE(T_W0_SAMPLE),
    .T_RD_PULSE (T_RD_PULSE),  .T_RD_SAMPLE(T_RD_SAMPLE),
    .T_RC_SAMPLE(T_RC_SAMPLE), .BYTE_W(8)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .bq_valid (bq_valid),
    .bq_ready (bq_ready),
    .bq_write (bq_write),
    .bq_data  (bq_data),
    .br_valid (br_valid),
    .br_ready (br_ready),
    .br_data  (br_data),
    .eng_busy (eng_busy),
    .eng_fin  (eng_fin),
    .eng_bit  (eng_bit),
    .req      (seq_req),
    .slot     (seq_slot),
    .idle     (seq_idle)
  );

  a_r5_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    eng_busy |-> !eng_start);
  a_r5_seq_excludes_host: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_we && !seq_idle) |=> $stable(status) || !$past(eng_busy) || eng_done);
endmodule

// File: tb/ow_master_tb.sv
`timescale 1ns/1ps
module ow_master_tb;
  localparam int DIV = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_we = 1'b0;
  logic [31:0] cmd_word = '0;
  logic [1:0]  status;
  logic        bq_valid = 1'b0, bq_write = 1'b0, br_ready = 1'b0;
  logic [7:0]  bq_data = '0;
  logic        bq_ready, br_valid;
  logic [7:0]  br_data;
  logic        ow_in, ow_drive_low;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  // simulated device: answers read slots on falling line
  logic       dev_en = 1'b0;
  logic [7:0] dev_byte = '0;
  logic [2:0] dev_idx;
  int         dev_cnt;
  logic       drv_d;
  always @(posedge clk) begin
    if (!rst_n || !dev_en) begin
      dev_idx <= '0;
      dev_cnt <= 0;
      drv_d   <= 1'b0;
    end else begin
      drv_d <= ow_drive_low;
      if (ow_drive_low && !drv_d) begin
        if (!dev_byte[dev_idx]) dev_cnt <= 30 * DIV;
        dev_idx <= dev_idx + 1'b1;
      end else if (dev_cnt > 0) dev_cnt <= dev_cnt - 1;
    end
  end
  assign ow_in = !(ow_drive_low || (dev_cnt > 0));

  // write-slot monitor: low pulse width gives the bit
  int         mon_len = 0;
  int         mon_bits = 0;
  logic [7:0] mon_byte = '0;
  logic       mon_clr = 1'b0;
  always @(posedge clk) begin
    if (mon_clr) begin
      mon_len <= 0; mon_bits <= 0; mon_byte <= '0;
    end else if (ow_drive_low) mon_len <= mon_len + 1;
    else if (mon_len > 0) begin
      mon_byte <= {(mon_len < 40 * DIV), mon_byte[7:1]};
      mon_bits <= mon_bits + 1;
      mon_len  <= 0;
    end
  end

  ow_master #(.CLK_HZ(4_000_000), .UNIT_HZ(1_000_000)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_word(cmd_word), .status(status),
    .bq_valid(bq_valid), .bq_ready(bq_ready), .bq_write(bq_write), .bq_data(bq_data),
    .br_valid(br_valid), .br_ready(br_ready), .br_data(br_data),
    .ow_in(ow_in), .ow_drive_low(ow_drive_low)
  );

  function automatic logic [31:0] pack(input int p, input int s);
    return (32'(p) << 12) | (32'(s) << 2);   // R1 field positions
  endfunction
  function automatic int seff(input int s);
    return (s == 0) ? 1 : s;
  endfunction
  function automatic int slot_len(input int p, input int s);
    return (p > seff(s)) ? p : seff(s);
  endfunction
  function automatic logic exp_bit(input int p, input int s);
    return (seff(s) <= p) ? 1'b0 : 1'b1;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  task automatic host_slot(input int p, input int s, input bit inj);
    int  len = slot_len(p, s);
    bit  drive_ok = 1'b1, done_ok = 1'b1;
    int  bad_k = -1;
    @(negedge clk); cmd_word = pack(p, s); cmd_we = 1'b1;
    @(posedge clk); @(negedge clk); cmd_we = 1'b0;
    for (int k = 0; k <= len * DIV; k++) begin
      if (k > 0) begin @(posedge clk); @(negedge clk); end
      if (ow_drive_low !== (k < p * DIV)) begin drive_ok = 1'b0; if (bad_k < 0) bad_k = k; end
      if (status[1] !== (k >= len * DIV)) begin done_ok = 1'b0; if (bad_k < 0) bad_k = k; end
      if (inj && k == 3) begin cmd_word = pack(0, 2); cmd_we = 1'b1; end
      if (inj && k == 4) cmd_we = 1'b0;
    end
    cmd_we = 1'b0;
    if (inj) check(drive_ok && done_ok && status[0] == exp_bit(p, s),
                   "R5 strobe during slot", bad_k, -1);
    else begin
      check(drive_ok, "R2 pull-down window", bad_k, p * DIV);
      check(done_ok, "R4 done timing", bad_k, len * DIV);
      check(status[0] == exp_bit(p, s), "R3 captured bit", status[0], exp_bit(p, s));
    end
  endtask

  task automatic send_req(input bit wr, input logic [7:0] d);
    @(negedge clk);
    while (!bq_ready) @(negedge clk);
    bq_valid = 1'b1; bq_write = wr; bq_data = d;
    @(posedge clk); @(negedge clk);
    bq_valid = 1'b0;
  endtask

  task automatic write_byte(input logic [7:0] b, input bit inj);
    @(negedge clk); mon_clr = 1'b1; @(negedge clk); mon_clr = 1'b0;
    send_req(1'b1, b);
    if (inj) begin
      repeat (500) @(negedge clk);
      cmd_word = pack(200, 5); cmd_we = 1'b1;
      @(negedge clk); cmd_we = 1'b0;
    end
    while (!(bq_ready && mon_bits >= 8)) @(negedge clk);
    repeat (4) @(negedge clk);
    if (inj) check(mon_bits == 8 && mon_byte == b, "R5 strobe during byte", mon_byte, b);
    else     check(mon_bits == 8 && mon_byte == b, "R6 written byte", mon_byte, b);
  endtask

  task automatic read_byte(input logic [7:0] b, input bit hold);
    bit stable_ok = 1'b1;
    logic [7:0] first;
    dev_byte = b; dev_en = 1'b1; br_ready = !hold;
    send_req(1'b0, 8'h00);
    while (!br_valid) @(negedge clk);
    first = br_data;
    check(br_data == b, "R7 read byte", br_data, b);
    if (hold) begin
      for (int i = 0; i < 40; i++) begin
        @(negedge clk);
        if (!br_valid || br_data != first || bq_ready) stable_ok = 1'b0;
      end
      check(stable_ok, "R8 result held under back-pressure", br_data, first);
      br_ready = 1'b1;
      @(negedge clk);
      br_ready = 1'b0;
      check(!br_valid && bq_ready, "R8 result released", br_valid, 0);
    end else begin
      @(negedge clk);
      check(!br_valid, "R8 result taken", br_valid, 0);
    end
    br_ready = 1'b0; dev_en = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    int seed;
    seed = $urandom(32'h5eed);
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(status == 2'b00 && !ow_drive_low && bq_ready && !br_valid,
          "R9 reset state", {status, ow_drive_low, bq_ready, br_valid}, 5'b00010);

    // directed slot shapes
    host_slot(500, 65, 1'b0);   // bus reset
    host_slot(0, 500, 1'b0);    // recovery
    host_slot(80, 30, 1'b0);
    host_slot(6, 110, 1'b0);
    host_slot(6, 13, 1'b0);
    host_slot(0, 0, 1'b0);
    host_slot(5, 5, 1'b0);
    host_slot(5, 6, 1'b0);
    host_slot(40, 50, 1'b1);

    // random slots (R1 decode via packed fields)
    for (int i = 0; i < 16; i++) host_slot($urandom_range(0, 30), $urandom_range(0, 30), 1'b0);

    write_byte(8'hA5, 1'b1);
    write_byte(8'h3C, 1'b0);
    for (int i = 0; i < 2; i++) write_byte(8'($urandom), 1'b0);

    read_byte(8'h96, 1'b0);
    read_byte(8'h5A, 1'b1);
    read_byte(8'($urandom), 1'b0);

    summary();
  end
endmodule